// File: doc/BRIEF.md
# Ternary-Logic and XOR-Permute Bit Unit

A combinational 64-bit bit-manipulation unit for an execution pipeline. A 2-bit operation code picks one of two functions. The first is a per-bit three-input lookup. Each result bit is read from an 8-entry truth table, and the table is indexed by the bits at that position in the three sources.

The second is a bit permutation driven by an XOR index. Each result bit is read from source A at the position formed by XOR-ing the result index with a control value taken from source B. Depending on the control value, this swaps single bits, pairs, nibbles, bytes, half-words or words. A mode flag narrows the permutation to the low 32 bits and zero-extends the result.

The result and its valid flag follow the inputs in the same cycle, with no register in the path.

Top module: `bitmix_unit`

## Requirements
- R1: With `op_i` = 0 (ternary lookup), `res_o[i]` equals `tbl_i[{src_c_i[i], src_a_i[i], src_b_i[i]}]` for every i. In the 3-bit index, C is bit 2, A is bit 1 and B is bit 0.
- R2: The ternary lookup ignores `w32_i` and always produces all 64 result bits.
- R3: With `op_i` = 1 (permute) and `w32_i` = 0, `res_o[i]` equals `src_a_i[i ^ src_b_i[5:0]]` for i from 0 to 63. `src_b_i[63:6]` and `src_c_i` have no effect.
- R4: With `op_i` = 1 and `w32_i` = 1, `res_o[i]` equals `src_a_i[i ^ src_b_i[4:0]]` for i from 0 to 31, and `res_o[63:32]` is zero.
- R5: In the permute, a control value of zero returns source A unchanged within the active width. A control value of all ones (63 in 64-bit mode, 31 in 32-bit mode) reverses the bit order within the active width.
- R6: `vld_o` is 1 for `op_i` values 0 and 1. For `op_i` values 2 and 3, `vld_o` is 0 and `res_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_i | input | 64 | Source A: middle lookup-index bit, and the permute data |
| src_b_i | input | 64 | Source B: lookup-index LSB, and the permute control in its low bits |
| src_c_i | input | 64 | Source C: lookup-index MSB |
| tbl_i | input | 8 | Truth table for the ternary lookup |
| w32_i | input | 1 | 32-bit permute mode |
| op_i | input | 2 | Operation code: 0 lookup, 1 permute, 2 and 3 unsupported |
| res_o | output | 64 | Result |
| vld_o | output | 1 | Result valid |

## Verification
The unit holds no state, so any fault shows at the ports in the same cycle as the stimulus that exposes it. A wrong index order in the lookup appears only with tables that are not symmetric in their inputs, so the bench applies the tables that select each single source.

A wrong bit in the XOR index moves whole groups of bits, and the group size depends on which bit is wrong. Running every control value in both widths therefore exposes such a fault. A lane-select fault in 32-bit mode shows as non-zero upper bits.

// File: rtl/bitmix_pkg.sv
package bitmix_pkg;
  localparam int unsigned XLEN  = 64;
  localparam int unsigned TBL_W = 8;
  localparam int unsigned OP_W  = 2;

  typedef enum logic [OP_W-1:0] {
    OP_TERN = 2'd0,
    OP_PERM = 2'd1
  } bitmix_op_e;
endpackage

// File: rtl/tern_lut_unit.sv
module tern_lut_unit #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [7:0]   tbl_i,
  output logic [W-1:0] y_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [2:0] idx;
    assign idx    = {c_i[i], a_i[i], b_i[i]};
    assign y_o[i] = tbl_i[idx];
  end
endmodule

// File: rtl/xor_permute_unit.sv
module xor_permute_unit #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0]         a_i,
  input  logic [$clog2(W)-1:0] ctl_i,
  input  logic                 half_i,
  output logic [W-1:0]         y_o
);
  localparam int unsigned IDX_W  = $clog2(W);
  localparam int unsigned HALF   = W / 2;
  localparam int unsigned HIDX_W = IDX_W - 1;

  logic [W-1:0]    full_y;
  logic [HALF-1:0] half_y;

  for (genvar i = 0; i < W; i++) begin : g_full
    localparam logic [IDX_W-1:0] POS = IDX_W'(i);
    logic [IDX_W-1:0] src;
    assign src       = POS ^ ctl_i;
    assign full_y[i] = a_i[src];
  end

  for (genvar i = 0; i < HALF; i++) begin : g_half
    localparam logic [HIDX_W-1:0] POS = HIDX_W'(i);
    logic [HIDX_W-1:0] src;
    assign src       = POS ^ ctl_i[HIDX_W-1:0];
    assign half_y[i] = a_i[src];
  end

  // 32-bit mode: zero-extend the low-half permutation
  assign y_o = half_i ? {{(W-HALF){1'b0}}, half_y} : full_y;
endmodule

// File: rtl/bitmix_unit.sv
module bitmix_unit
  import bitmix_pkg::*;
(
  input  logic [XLEN-1:0]  src_a_i,
  input  logic [XLEN-1:0]  src_b_i,
  input  logic [XLEN-1:0]  src_c_i,
  input  logic [TBL_W-1:0] tbl_i,
  input  logic             w32_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [XLEN-1:0]  res_o,
  output logic             vld_o
);
  localparam int unsigned IDX_W = $clog2(XLEN);

  logic [XLEN-1:0] tern_y;
  logic [XLEN-1:0] perm_y;

  tern_lut_unit #(.W(XLEN)) i_tern (
    .a_i  (src_a_i),
    .b_i  (src_b_i),
    .c_i  (src_c_i),
    .tbl_i(tbl_i),
    .y_o  (tern_y)
  );

  xor_permute_unit #(.W(XLEN)) i_perm (
    .a_i   (src_a_i),
    .ctl_i (src_b_i[IDX_W-1:0]),
    .half_i(w32_i),
    .y_o   (perm_y)
  );

  always_comb begin
    res_o = '0;
    vld_o = 1'b0;
    case (op_i)
      OP_TERN: begin res_o = tern_y; vld_o = 1'b1; end
      OP_PERM: begin res_o = perm_y; vld_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/bitmix_chk.sv
module bitmix_chk
  import bitmix_pkg::*;
(
  input logic [XLEN-1:0]  src_a_i,
  input logic [XLEN-1:0]  src_b_i,
  input logic [XLEN-1:0]  src_c_i,
  input logic [TBL_W-1:0] tbl_i,
  input logic             w32_i,
  input logic [OP_W-1:0]  op_i,
  input logic [XLEN-1:0]  res_o,
  input logic             vld_o
);
  always_comb begin
    // R6
    vld_op_chk: assert (vld_o == (op_i < 2'd2));
    // R6
    inv_zero_chk: assert (vld_o || res_o == '0);
    // R4
    hi_zero_chk: assert (!(op_i == 2'd1 && w32_i) || res_o[XLEN-1:XLEN/2] == '0);
    for (int i = 0; i < XLEN; i++) begin
      // R1 R2
      tern_bit_chk: assert (op_i != 2'd0 ||
        res_o[i] == tbl_i[{src_c_i[i], src_a_i[i], src_b_i[i]}]);
      // R3
      perm64_bit_chk: assert (op_i != 2'd1 || w32_i ||
        res_o[i] == src_a_i[6'(i) ^ src_b_i[5:0]]);
    end
    for (int i = 0; i < XLEN/2; i++) begin
      // R4
      perm32_bit_chk: assert (op_i != 2'd1 || !w32_i ||
        res_o[i] == src_a_i[{1'b0, 5'(i) ^ src_b_i[4:0]}]);
    end
  end
endmodule

bind bitmix_unit bitmix_chk i_chk (
  .src_a_i(src_a_i), .src_b_i(src_b_i), .src_c_i(src_c_i), .tbl_i(tbl_i),
  .w32_i(w32_i), .op_i(op_i), .res_o(res_o), .vld_o(vld_o)
);

// File: tb/test_bitmix_unit.sv
module test_bitmix_unit;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [63:0] a, b, c, res;
  logic [7:0]  tbl;
  logic        w32, vld;
  logic [1:0]  op;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  bitmix_unit i_bitmix_unit (
    .src_a_i(a), .src_b_i(b), .src_c_i(c), .tbl_i(tbl),
    .w32_i(w32), .op_i(op), .res_o(res), .vld_o(vld)
  );

  function automatic logic [63:0] m_tern(logic [63:0] x, logic [63:0] y,
                                         logic [63:0] z, logic [7:0] t);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = t[{z[i], x[i], y[i]}];
    return r;
  endfunction

  function automatic logic [63:0] m_perm(logic [63:0] x, logic [63:0] y, logic h);
    logic [63:0] r = '0;
    int n = h ? 32 : 64;
    int k = h ? int'(y[4:0]) : int'(y[5:0]);
    for (int i = 0; i < n; i++) r[i] = x[i ^ k];
    return r;
  endfunction

  function automatic logic [63:0] m_rev(logic [63:0] x, int n);
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = x[n-1-i];
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] o, logic h, logic [63:0] x, logic [63:0] y,
                       logic [63:0] z, logic [7:0] t);
    @(posedge clk);
    op = o; w32 = h; a = x; b = y; c = z; tbl = t;
    @(negedge clk);
  endtask

  initial begin
    op = 2'd0; w32 = 1'b0; a = '0; b = '0; c = '0; tbl = '0;
    @(negedge clk);
    // R1 R6: initial, all-zero inputs
    chk("R6 init vld", 64'(vld), 64'd1);
    chk("R1 init res", res, 64'd0);

    // R1: tables selecting one source each, proving index order
    drive(2'd0, 1'b0, 64'hF0F0_1234_5678_9ABC, 64'h0FF0_AAAA_5555_0001,
          64'h8000_0000_FFFF_0000, 8'hAA);
    chk("R1 tbl AA -> B", res, b);
    drive(2'd0, 1'b0, a, b, c, 8'hCC);
    chk("R1 tbl CC -> A", res, a);
    drive(2'd0, 1'b0, a, b, c, 8'hF0);
    chk("R1 tbl F0 -> C", res, c);
    drive(2'd0, 1'b0, a, b, c, 8'h96);
    chk("R1 xor3", res, a ^ b ^ c);
    // R2: w32 ignored
    drive(2'd0, 1'b1, a, b, c, 8'hE8);
    chk("R2 w32 ignored", res, m_tern(a, b, c, 8'hE8));

    // R5: identity and reversal
    drive(2'd1, 1'b0, 64'hDEAD_BEEF_0123_4567, 64'd0, '0, '0);
    chk("R5 id64", res, a);
    drive(2'd1, 1'b0, a, 64'd63, '0, '0);
    chk("R5 rev64", res, m_rev(a, 64));
    drive(2'd1, 1'b1, a, 64'd0, '0, '0);
    chk("R5 id32", res, {32'd0, a[31:0]});
    drive(2'd1, 1'b1, a, 64'd31, '0, '0);
    chk("R5 rev32", res, m_rev(a, 32));

    // R3 R4: every control value, junk in upper B and in C
    for (int k = 0; k < 64; k++) begin
      drive(2'd1, 1'b0, 64'h0123_4567_89AB_CDEF, {58'h2A5A5A5A5A5A5A5, 6'(k)},
            64'hFFFF_FFFF_FFFF_FFFF, 8'h55);
      chk("R3 perm64 ctl sweep", res, m_perm(a, b, 1'b0));
      drive(2'd1, 1'b1, 64'hFEDC_BA98_7654_3210, {58'h15A5A5A5A5A5A5A, 6'(k)},
            '0, '0);
      chk("R4 perm32 ctl sweep", res, m_perm(a, b, 1'b1));
    end

    // R6: unsupported codes
    for (int o = 2; o < 4; o++) begin
      drive(2'(o), 1'b0, '1, '1, '1, 8'hFF);
      chk("R6 bad op res", res, 64'd0);
      chk("R6 bad op vld", 64'(vld), 64'd0);
    end

    // random mix
    void'($urandom(32'd4242));
    for (int n = 0; n < 400; n++) begin
      logic [1:0] ro = 2'($urandom_range(3));
      logic rh = 1'($urandom);
      logic [63:0] ra = {$urandom, $urandom};
      logic [63:0] rb = {$urandom, $urandom};
      logic [63:0] rc = {$urandom, $urandom};
      logic [7:0]  rt = 8'($urandom);
      drive(ro, rh, ra, rb, rc, rt);
      case (ro)
        2'd0: chk("R1 R2 rand tern", res, m_tern(ra, rb, rc, rt));
        2'd1: chk(rh ? "R4 rand perm32" : "R3 rand perm64", res, m_perm(ra, rb, rh));
        default: chk("R6 rand bad op", res, 64'd0);
      endcase
      chk("R6 rand vld", 64'(vld), 64'(ro < 2'd2));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule